// File: doc/BRIEF.md
# Posted Write Buffer Controller

This block sits between the slave port of a processor-side local bus and the master port of a PCI-style bus. It looks at each incoming request and sorts it by direction and by target address space. Writes to memory or I/O space are posted. Such a write is stored in a two-entry queue and acknowledged in the same cycle. The queue then drains downstream in the order the writes arrived. A posted write that finds the queue full is returned to the upstream bus for rearbitration.

Some requests are never posted: reads of any space, writes to configuration space and special-cycle writes. Each of these waits until the queue is empty. It is then offered on a separate non-posted request line. The address is acknowledged only when the downstream side reports that the transfer has completed. A write to the block's own internal registers also waits for an empty queue, and then fires a one-cycle register write strobe. The queue is never snooped. The request fields (address, data, byte enables, space) stay on the request bus for the downstream master to read while the non-posted line is high.

Top module: `postWriteBuffer`

## Requirements
- R1: After reset, `bufEmpty` is 1 and `drainValid`, `reqAccept`, `reqRearb`, `npValid` and `regWe` are 0 while no request is presented.
- R2: A valid write with `reqLocal`=0 and `reqSpace` 2'b00 (memory) or 2'b01 (I/O) is acknowledged in the same cycle through `reqAccept` when fewer than 2 entries are held. From the next cycle the queue is not empty.
- R3: Such a posted write is answered with `reqRearb`, not `reqAccept`, while 2 entries are held. It is not stored, so it never appears on the drain port.
- R4: Writes with `reqSpace` 2'b10 (configuration) or 2'b11 (special cycle) are never stored. `npValid` rises only when the queue is empty, and `reqAccept` comes only in a cycle where `npDone` is 1. Until then `reqStall` is 1.
- R5: Stored entries leave on the drain port (`drainAddr`, `drainData`, `drainBe`, `drainSpace`) in their arrival order. One entry leaves per cycle in which `drainValid` and `drainReady` are both 1.
- R6: A read (`reqWrite`=0, `reqLocal`=0) of any space is stalled with `npValid`=0 while any entry is held. It is forwarded and acknowledged as in R4 once the queue is empty.
- R7: A write with `reqLocal`=1 is held with `reqStall`=1 and `regWe`=0 while any entry is held. When the queue is empty it gets `regWe` and `reqAccept` in the same cycle, without `npValid`.
- R8: `bufEmpty` is registered. It rises in the cycle after the final drain handshake, so a non-posted or local request presented in that drain cycle still stalls.
- R9: While `drainValid` is 1 and `drainReady` is 0, the drain port fields hold their values.
- R10: Full/free is judged on the held state at the start of the cycle. A posted write is rearbitrated at 2 entries even if an entry drains in that cycle. A posted write at 1 entry during a drain is accepted, and the queue keeps 1 entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Upstream request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLocal | input | 1 | Request targets the block's internal registers |
| reqSpace | input | 2 | 00 memory, 01 I/O, 10 configuration, 11 special cycle |
| reqAddr | input | AW | Request address |
| reqData | input | DW | Write data |
| reqBe | input | DW/8 | Byte enables |
| reqAccept | output | 1 | Address acknowledge for the current request |
| reqRearb | output | 1 | Request refused; retry later |
| reqStall | output | 1 | Request held; keep it presented |
| regWe | output | 1 | Internal register write strobe |
| npValid | output | 1 | Non-posted request offered downstream (fields on request bus) |
| npDone | input | 1 | Downstream has completed the non-posted request |
| drainValid | output | 1 | Head entry offered downstream |
| drainReady | input | 1 | Downstream takes the head entry |
| drainAddr | output | AW | Head entry address |
| drainData | output | DW | Head entry data |
| drainBe | output | DW/8 | Head entry byte enables |
| drainSpace | output | 2 | Head entry address space |
| bufEmpty | output | 1 | Registered: no entry held |

## Verification
A wrong pointer shows as a reordered or repeated entry on the drain port, and it does so on the first handshake after the fault. A wrong occupancy count shows at once: a rearbitration where an accept was due, or an accept where a rearbitration was due. A wrong occupancy count also lets a read, configuration write or local register write through while data is still queued, and that is visible as early `npValid` or `regWe` in the same cycle. An empty flag that rises one cycle early lets a stalled request through during the final drain cycle, so that cycle is sampled on its own.

// File: rtl/pwbPkg.sv
package pwbPkg;
  typedef enum logic [1:0] {
    SP_MEM     = 2'b00,
    SP_IO      = 2'b01,
    SP_CFG     = 2'b10,
    SP_SPECIAL = 2'b11
  } spaceT;

  typedef struct packed {
    logic push;
    logic pop;
  } strobeT;
endpackage

// File: rtl/pwbCtrl.sv
module pwbCtrl
  import pwbPkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqLocal,
  input  spaceT            reqSpace,
  input  logic             npDone,
  input  logic             drainReady,
  output logic             reqAccept,
  output logic             reqRearb,
  output logic             reqStall,
  output logic             regWe,
  output logic             npValid,
  output logic             drainValid,
  output logic             isEmpty,
  output strobeT           strobe,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic postable, isFull, npFwd, localOk;

  assign postable = reqWrite && !reqLocal &&
                    (reqSpace == SP_MEM || reqSpace == SP_IO);
  assign isEmpty  = (count == '0);
  assign isFull   = (count == FULL_CNT);

  assign strobe.push = reqValid && postable && !isFull;
  assign strobe.pop  = !isEmpty && drainReady;

  assign npFwd      = reqValid && !postable && !reqLocal && isEmpty;
  assign localOk    = reqValid && reqLocal && isEmpty;
  assign npValid    = npFwd;
  assign regWe      = localOk && reqWrite;
  assign reqRearb   = reqValid && postable && isFull;
  assign reqAccept  = strobe.push || (npFwd && npDone) || localOk;
  assign reqStall   = reqValid && !postable && !reqAccept;
  assign drainValid = !isEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrIdx <= '0;
      rdIdx <= '0;
    end else begin
      if (strobe.push) wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + PTR_W'(1);
      if (strobe.pop)  rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + PTR_W'(1);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pwbData.sv
module pwbData
  import pwbPkg::*;
#(
  parameter int DEPTH = 2,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [PTR_W-1:0] wrIdx,
  input  logic [PTR_W-1:0] rdIdx,
  input  logic [AW-1:0]    reqAddr,
  input  logic [DW-1:0]    reqData,
  input  logic [BEW-1:0]   reqBe,
  input  spaceT            reqSpace,
  output logic [AW-1:0]    drainAddr,
  output logic [DW-1:0]    drainData,
  output logic [BEW-1:0]   drainBe,
  output spaceT            drainSpace
);
  typedef struct packed {
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
    logic [BEW-1:0] be;
    spaceT          space;
  } entryT;

  entryT slots [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slots[g] <= '0;
      end else if (strobe.push && wrIdx == PTR_W'(g)) begin
        slots[g] <= '{addr: reqAddr, data: reqData, be: reqBe, space: reqSpace};
      end
    end
  end

  assign drainAddr  = slots[rdIdx].addr;
  assign drainData  = slots[rdIdx].data;
  assign drainBe    = slots[rdIdx].be;
  assign drainSpace = slots[rdIdx].space;
endmodule

// File: rtl/postWriteBuffer.sv
module postWriteBuffer
  import pwbPkg::*;
#(
  parameter int DEPTH = 2,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BEW  = DW / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic           reqWrite,
  input  logic           reqLocal,
  input  logic [1:0]     reqSpace,
  input  logic [AW-1:0]  reqAddr,
  input  logic [DW-1:0]  reqData,
  input  logic [BEW-1:0] reqBe,
  output logic           reqAccept,
  output logic           reqRearb,
  output logic           reqStall,
  output logic           regWe,
  output logic           npValid,
  input  logic           npDone,
  output logic           drainValid,
  input  logic           drainReady,
  output logic [AW-1:0]  drainAddr,
  output logic [DW-1:0]  drainData,
  output logic [BEW-1:0] drainBe,
  output logic [1:0]     drainSpace,
  output logic           bufEmpty
);
  strobeT           strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  spaceT            headSpace;

  pwbCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLocal(reqLocal),
    .reqSpace(spaceT'(reqSpace)),
    .npDone(npDone), .drainReady(drainReady),
    .reqAccept(reqAccept), .reqRearb(reqRearb), .reqStall(reqStall),
    .regWe(regWe), .npValid(npValid), .drainValid(drainValid),
    .isEmpty(bufEmpty), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  pwbData #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .reqAddr(reqAddr), .reqData(reqData), .reqBe(reqBe),
    .reqSpace(spaceT'(reqSpace)),
    .drainAddr(drainAddr), .drainData(drainData), .drainBe(drainBe),
    .drainSpace(headSpace)
  );

  assign drainSpace = headSpace;
endmodule

// File: rtl/pwbChecker.sv
module pwbChecker #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int BEW = DW / 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic           reqWrite,
  input logic           reqLocal,
  input logic [1:0]     reqSpace,
  input logic           reqAccept,
  input logic           reqRearb,
  input logic           regWe,
  input logic           npValid,
  input logic           drainValid,
  input logic           drainReady,
  input logic [AW-1:0]  drainAddr,
  input logic [DW-1:0]  drainData,
  input logic [BEW-1:0] drainBe,
  input logic           bufEmpty
);
  logic postedAcc;
  assign postedAcc = reqAccept && reqWrite && !reqLocal && !reqSpace[1];

  assert_post_fill_R2: assert property (@(posedge clk) disable iff (!rstN)
    postedAcc |=> !bufEmpty);

  assert_rearb_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqRearb |-> (!reqAccept && drainValid));

  assert_np_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    npValid |-> bufEmpty);

  assert_read_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept && !reqWrite) |-> bufEmpty);

  assert_local_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (bufEmpty && !npValid));

  assert_empty_lag_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> $past(drainValid && drainReady));

  assert_drain_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && !drainReady) |=>
      (drainValid && $stable(drainAddr) && $stable(drainData) && $stable(drainBe)));
endmodule

bind postWriteBuffer pwbChecker #(.AW(AW), .DW(DW)) u_pwbChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqLocal(reqLocal), .reqSpace(reqSpace), .reqAccept(reqAccept),
  .reqRearb(reqRearb), .regWe(regWe), .npValid(npValid),
  .drainValid(drainValid), .drainReady(drainReady), .drainAddr(drainAddr),
  .drainData(drainData), .drainBe(drainBe), .bufEmpty(bufEmpty)
);

// File: tb/tb_postWriteBuffer.sv
module tb_postWriteBuffer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqLocal = 0;
  logic [1:0] reqSpace = 0;
  logic [AW-1:0] reqAddr = 0;
  logic [DW-1:0] reqData = 0;
  logic [BEW-1:0] reqBe = 0;
  logic npDone = 0, drainReady = 0;
  logic reqAccept, reqRearb, reqStall, regWe, npValid, drainValid, bufEmpty;
  logic [AW-1:0] drainAddr;
  logic [DW-1:0] drainData;
  logic [BEW-1:0] drainBe;
  logic [1:0] drainSpace;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  postWriteBuffer #(.DEPTH(2), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLocal(reqLocal), .reqSpace(reqSpace), .reqAddr(reqAddr),
    .reqData(reqData), .reqBe(reqBe), .reqAccept(reqAccept),
    .reqRearb(reqRearb), .reqStall(reqStall), .regWe(regWe),
    .npValid(npValid), .npDone(npDone), .drainValid(drainValid),
    .drainReady(drainReady), .drainAddr(drainAddr), .drainData(drainData),
    .drainBe(drainBe), .drainSpace(drainSpace), .bufEmpty(bufEmpty)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setReq(input bit w, input bit loc, input logic [1:0] sp,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [BEW-1:0] be);
    reqValid = 1; reqWrite = w; reqLocal = loc; reqSpace = sp;
    reqAddr = a; reqData = d; reqBe = be;
    #1;
  endtask

  task automatic idle();
    reqValid = 0; reqWrite = 0; reqLocal = 0; reqSpace = 0;
    #1;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [1:0] sp);
    setReq(1, 0, sp, a, d, 4'hF);
    chk(reqAccept && !reqRearb, "R2 posted accept", {reqAccept, reqRearb}, 2'b10);
    step();
    idle();
  endtask

  task automatic tReset();
    chk(bufEmpty == 1, "R1 bufEmpty", bufEmpty, 1);
    chk(!drainValid && !reqAccept && !reqRearb && !npValid && !regWe,
        "R1 outputs idle", {drainValid, reqAccept, reqRearb, npValid, regWe}, 0);
  endtask

  task automatic tPostFill();
    setReq(1, 0, 2'b00, 32'h1000, 32'hA1, 4'hF);
    chk(reqAccept && !reqRearb, "R2 mem accept", {reqAccept, reqRearb}, 2'b10);
    step();
    setReq(1, 0, 2'b01, 32'h2000, 32'hA2, 4'h3);
    chk(reqAccept && !bufEmpty, "R2 io accept, not empty", {reqAccept, bufEmpty}, 2'b10);
    step();
    setReq(1, 0, 2'b00, 32'h3000, 32'hA3, 4'hF);
    chk(reqRearb && !reqAccept, "R3 full rearb", {reqRearb, reqAccept}, 2'b10);
    step();
    idle();
    chk(drainValid && drainAddr == 32'h1000, "R5 head first", drainAddr, 32'h1000);
    step();
    chk(drainAddr == 32'h1000 && drainData == 32'hA1, "R9 hold", drainData, 32'hA1);
    drainReady = 1;
    step();
    chk(drainAddr == 32'h2000 && drainSpace == 2'b01 && drainBe == 4'h3,
        "R5 second in order", drainAddr, 32'h2000);
    step();
    drainReady = 0;
    #1;
    chk(bufEmpty && !drainValid, "R3 refused write not stored",
        {bufEmpty, drainValid}, 2'b10);
  endtask

  task automatic tNonPosted(input logic [1:0] sp);
    push(32'h4000, 32'hB1, 2'b00);
    setReq(1, 0, sp, 32'h5000, 32'hC1, 4'hF);
    chk(reqStall && !npValid && !reqAccept, "R4 held while queued",
        {reqStall, npValid, reqAccept}, 3'b100);
    drainReady = 1;
    #1;
    chk(!npValid && reqStall, "R8 stall in final drain cycle", {npValid, reqStall}, 2'b01);
    step();
    drainReady = 0;
    #1;
    chk(npValid && reqStall && !reqAccept, "R4 forwarded, awaiting done",
        {npValid, reqStall, reqAccept}, 3'b110);
    step();
    npDone = 1;
    #1;
    chk(reqAccept && !reqStall, "R4 accept on done", {reqAccept, reqStall}, 2'b10);
    step();
    npDone = 0;
    idle();
    chk(bufEmpty && !drainValid, "R4 not posted", {bufEmpty, drainValid}, 2'b10);
  endtask

  task automatic tRead();
    push(32'h6000, 32'hD1, 2'b00);
    push(32'h6004, 32'hD2, 2'b01);
    setReq(0, 0, 2'b00, 32'h7000, 32'h0, 4'hF);
    chk(reqStall && !npValid, "R6 read held (2 queued)", {reqStall, npValid}, 2'b10);
    drainReady = 1;
    step();
    chk(!npValid && !reqAccept, "R6 read held (1 queued)", {npValid, reqAccept}, 0);
    step();
    drainReady = 0;
    #1;
    chk(npValid && !reqAccept, "R6 read forwarded", {npValid, reqAccept}, 2'b10);
    npDone = 1;
    #1;
    chk(reqAccept, "R6 read accepted", reqAccept, 1);
    step();
    npDone = 0;
    idle();
  endtask

  task automatic tLocal();
    push(32'h8000, 32'hE1, 2'b00);
    setReq(1, 1, 2'b10, 32'h0010, 32'h55, 4'hF);
    chk(!regWe && reqStall && !reqAccept, "R7 local write held",
        {regWe, reqStall, reqAccept}, 3'b010);
    drainReady = 1;
    step();
    drainReady = 0;
    #1;
    chk(regWe && reqAccept && !npValid, "R7 local write fires",
        {regWe, reqAccept, npValid}, 3'b110);
    step();
    idle();
  endtask

  task automatic tFullDrain();
    push(32'h9000, 32'hF1, 2'b00);
    push(32'h9004, 32'hF2, 2'b00);
    drainReady = 1;
    setReq(1, 0, 2'b00, 32'h9008, 32'hF3, 4'hF);
    chk(reqRearb && !reqAccept, "R10 full during drain rearb",
        {reqRearb, reqAccept}, 2'b10);
    step();
    setReq(1, 0, 2'b01, 32'h900C, 32'hF4, 4'hF);
    chk(reqAccept && !reqRearb, "R10 accept while draining", {reqAccept, reqRearb}, 2'b10);
    step();
    drainReady = 0;
    idle();
    chk(!bufEmpty && drainAddr == 32'h900C && drainData == 32'hF4,
        "R10 one entry kept, F4 at head", drainAddr, 32'h900C);
    drainReady = 1;
    step();
    drainReady = 0;
    #1;
    chk(bufEmpty, "R5 queue drained", bufEmpty, 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    tReset();
    @(negedge clk);
    tPostFill();
    tNonPosted(2'b10);
    tNonPosted(2'b11);
    tRead();
    tLocal();
    tFullDrain();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule